// File: doc/BRIEF.md
# Conversion Start and Auto-Trigger Sequencer

This block decides when an analog-to-digital conversion begins and tracks it until the converter reports completion. A conversion can be launched in two ways. Software can write a one to the start bit. Alternatively, when automatic triggering is enabled, a rising edge on one selected trigger input launches it. On each launch the block emits a one-cycle start pulse to the converter, together with the channel number captured at that moment. A launch caused by a trigger edge also emits a one-cycle pulse that resets the clock prescaler.

While a conversion runs, the block holds its busy status high and ignores further launch requests. When the converter signals done, busy drops and a sticky completion flag is raised. The flag is raised whether or not anything downstream uses it as an interrupt, and software clears it by writing a one. Channel selections made during a conversion take effect only at the next launch. Clearing the enable input aborts any conversion and blocks all launches.

Top module: `conv_start_seq`

## Requirements
- R1: During and after reset, until the first launch, busy, startPulse, prescRst and irqFlag are 0 and startChan is 0. The registered trigger history resets to 1, so a trigger that is already high when reset is released is not taken as a rising edge.
- R2: When startWr is 1, enable is 1 and busy is 0 at a clock edge, then after that edge busy is 1 and startPulse is 1 for exactly one cycle. prescRst stays 0 unless the same cycle also qualifies as a trigger launch.
- R3: busy stays 1 until convDone is sampled as 1 while busy and enable are both 1. busy is 0 in the cycle after that edge.
- R4: While enable is 0, no launch occurs. busy is 0 from the cycle after enable is sampled 0, and a convDone in that state does not set irqFlag.
- R5: With autoEn at 1, a trigger edge launches a conversion: trigIn is 1 at a clock edge after being 0 at the previous edge, while enable is 1 and busy is 0. After that edge, startPulse, prescRst and busy are all 1, and startPulse and prescRst each last one cycle.
- R6: A trigger edge or a startWr that arrives while busy is 1 is dropped. This includes the cycle in which convDone arrives. It produces no startPulse, then or later.
- R7: A trigger that is held high through the completion of a conversion does not launch another one. Only a later rising edge does.
- R8: startChan changes only together with startPulse. It then equals the chanSel value sampled at the launching edge, so a chanSel change during a conversion appears at the next launch.
- R9: irqFlag is 1 from the cycle after convDone is accepted while busy. A convDone while idle changes nothing.
- R10: flagClr at 1 clears irqFlag at the next edge. When a clear and an accepted convDone coincide, irqFlag ends up 1.
- R11: With autoEn at 0, edges on trigIn launch nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter enable; 0 aborts and blocks conversions |
| startWr | input | 1 | Software write of one to the start bit |
| autoEn | input | 1 | Automatic trigger enable |
| trigIn | input | 1 | Selected trigger signal |
| chanSel | input | CH_W | Requested channel |
| convDone | input | 1 | Completion from the converter |
| flagClr | input | 1 | Write of one to the completion flag |
| busy | output | 1 | Start/busy status bit |
| startPulse | output | 1 | One-cycle launch to the converter |
| prescRst | output | 1 | One-cycle prescaler reset on a trigger launch |
| startChan | output | CH_W | Channel latched at the last launch |
| irqFlag | output | 1 | Sticky completion flag |

## Verification
A busy register stuck high or cleared early shows at the busy port in the next cycle. It also shows as missing or extra start pulses once the next request arrives. A corrupted trigger history shows as a start pulse that appears, or fails to appear, one cycle after the trigger is sampled, most sharply when the trigger is held high across a completion. A wrong channel capture shows on startChan in the very cycle of the pulse, or as startChan moving without a pulse.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic loadChan;   // capture the requested channel for a new conversion
  } seqStrobe_t;
endpackage

// File: rtl/conv_seq_datapath.sv
module conv_seq_datapath
  import conv_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trigIn,
  input  logic [CH_W-1:0] chanSel,
  input  seqStrobe_t      stb,
  output logic            trigEdge,
  output logic [CH_W-1:0] startChan
);
  logic trigPrev;

  always_ff @(posedge clk) begin
    if (!rstN) trigPrev <= 1'b1;
    else       trigPrev <= trigIn;
  end

  assign trigEdge = trigIn & ~trigPrev;

  always_ff @(posedge clk) begin
    if (!rstN)             startChan <= '0;
    else if (stb.loadChan) startChan <= chanSel;
  end

  // R8: the channel presented to the converter moves only on a launch
  p_chan_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadChan |=> $stable(startChan));
endmodule

// File: rtl/conv_seq_control.sv
module conv_seq_control
  import conv_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       startWr,
  input  logic       autoEn,
  input  logic       trigEdge,
  input  logic       convDone,
  input  logic       flagClr,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       startPulse,
  output logic       prescRst,
  output logic       irqFlag
);
  logic autoHit, launch, doneAcc;

  assign autoHit = autoEn & trigEdge;
  assign launch  = enable & ~busy & (startWr | autoHit);
  assign doneAcc = enable & busy & convDone;

  always_comb begin
    stb          = '0;
    stb.loadChan = launch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      startPulse <= 1'b0;
      prescRst   <= 1'b0;
      irqFlag    <= 1'b0;
    end else begin
      startPulse <= launch;
      prescRst   <= launch & autoHit;
      if (!enable)      busy <= 1'b0;
      else if (launch)  busy <= 1'b1;
      else if (doneAcc) busy <= 1'b0;
      if (doneAcc)      irqFlag <= 1'b1;
      else if (flagClr) irqFlag <= 1'b0;
    end
  end

  p_pulse_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> busy);
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);
  p_presc_with_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    prescRst |-> startPulse);
  p_off_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busy);
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && enable && !convDone) |=> busy);
  p_done_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && enable && convDone) |=> irqFlag);
endmodule

// File: rtl/conv_start_seq.sv
module conv_start_seq
  import conv_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            startWr,
  input  logic            autoEn,
  input  logic            trigIn,
  input  logic [CH_W-1:0] chanSel,
  input  logic            convDone,
  input  logic            flagClr,
  output logic            busy,
  output logic            startPulse,
  output logic            prescRst,
  output logic [CH_W-1:0] startChan,
  output logic            irqFlag
);
  seqStrobe_t stb;
  logic       trigEdge;

  conv_seq_datapath #(.CH_W(CH_W)) dp_i (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .chanSel(chanSel),
    .stb(stb), .trigEdge(trigEdge), .startChan(startChan)
  );

  conv_seq_control ctl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .startWr(startWr),
    .autoEn(autoEn), .trigEdge(trigEdge), .convDone(convDone),
    .flagClr(flagClr), .stb(stb), .busy(busy), .startPulse(startPulse),
    .prescRst(prescRst), .irqFlag(irqFlag)
  );
endmodule

// File: tb/conv_start_seq_tb.sv
module conv_start_seq_tb_top;
  localparam int CH_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, startWr = 1'b0, autoEn = 1'b0, trigIn = 1'b0;
  logic convDone = 1'b0, flagClr = 1'b0;
  logic [CH_W-1:0] chanSel = '0;
  logic busy, startPulse, prescRst, irqFlag;
  logic [CH_W-1:0] startChan;

  int nChk = 0, nFail = 0;
  bit finished = 0;

  // expected-state model
  bit mPrev, mBusy, mPulse, mPresc, mIrq;
  logic [CH_W-1:0] mChan;

  always #5 clk = ~clk;

  conv_start_seq #(.CH_W(CH_W)) dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    mPrev = 1; mBusy = 0; mPulse = 0; mPresc = 0; mIrq = 0; mChan = '0;
  endfunction

  function automatic void modelStep(bit en, bit sw, bit ae, bit trg,
                                    logic [CH_W-1:0] ch, bit dn, bit clr);
    bit edgeSeen, go, acc;
    edgeSeen = trg && !mPrev;
    go  = en && !mBusy && (sw || (ae && edgeSeen));
    acc = en && mBusy && dn;
    mPulse = go;
    mPresc = go && ae && edgeSeen;
    if (go) mChan = ch;
    if (!en) mBusy = 0; else if (go) mBusy = 1; else if (acc) mBusy = 0;
    if (acc) mIrq = 1; else if (clr) mIrq = 0;
    mPrev = trg;
  endfunction

  task automatic compareAll();
    chk("R3 busy", busy, mBusy);
    chk("R2 startPulse", startPulse, mPulse);
    chk("R5 prescRst", prescRst, mPresc);
    chk("R8 startChan", startChan, mChan);
    chk("R9 irqFlag", irqFlag, mIrq);
  endtask

  task automatic step(bit en, bit sw, bit ae, bit trg, logic [CH_W-1:0] ch,
                      bit dn, bit clr);
    @(negedge clk);
    enable = en; startWr = sw; autoEn = ae; trigIn = trg; chanSel = ch;
    convDone = dn; flagClr = clr;
    @(posedge clk);
    modelStep(en, sw, ae, trg, ch, dn, clr);
    #1 compareAll();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    modelReset();
    trigIn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy", busy, 0); chk("R1 startPulse", startPulse, 0);
    chk("R1 prescRst", prescRst, 0); chk("R1 irqFlag", irqFlag, 0);
    chk("R1 startChan", startChan, 0);
    @(negedge clk) rstN = 1'b1;
    // trigger already high at reset release: not an edge
    step(1, 0, 1, 1, 0, 0, 0);
    chk("R1 no edge after reset", startPulse, 0);
    step(1, 0, 0, 0, 0, 0, 0);

    // software start and channel capture
    step(1, 1, 0, 0, 5, 0, 0);
    chk("R2 pulse", startPulse, 1); chk("R2 chan", startChan, 5);
    chk("R2 no presc", prescRst, 0);
    step(1, 0, 0, 0, 3, 0, 0);
    chk("R8 chan held", startChan, 5); chk("R2 single pulse", startPulse, 0);
    step(1, 1, 0, 0, 3, 0, 0);
    chk("R6 start while busy", startPulse, 0);
    step(1, 0, 0, 0, 3, 1, 0);
    chk("R3 done clears", busy, 0); chk("R9 flag set", irqFlag, 1);
    step(1, 0, 0, 0, 3, 0, 1);
    chk("R10 clear", irqFlag, 0);
    step(1, 0, 0, 0, 3, 1, 0);
    chk("R9 idle done ignored", irqFlag, 0);
    step(1, 1, 0, 0, 3, 0, 0);
    chk("R8 new chan", startChan, 3);
    step(1, 0, 0, 0, 3, 1, 1);
    chk("R10 set wins", irqFlag, 1);
    step(1, 0, 0, 0, 3, 0, 1);

    // automatic trigger, held high through completion
    step(1, 0, 1, 0, 6, 0, 0);
    step(1, 0, 1, 1, 6, 0, 0);
    chk("R5 pulse", startPulse, 1); chk("R5 presc", prescRst, 1);
    step(1, 0, 1, 1, 2, 1, 0);
    chk("R5 done", busy, 0);
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 1, 1, 2, 0, 0);
      chk("R7 held trigger", startPulse, 0);
    end
    // edge during busy, and edge in done cycle
    step(1, 0, 1, 0, 2, 0, 0);
    step(1, 0, 1, 1, 2, 0, 0);
    chk("R5 second pulse", startPulse, 1);
    step(1, 0, 1, 0, 2, 0, 0);
    step(1, 0, 1, 1, 2, 0, 0);
    chk("R6 edge while busy", startPulse, 0);
    step(1, 0, 1, 0, 2, 0, 0);
    step(1, 0, 1, 1, 2, 1, 0);
    step(1, 0, 1, 1, 2, 0, 0);
    chk("R6 edge in done cycle", startPulse, 0);
    chk("R6 idle after drop", busy, 0);

    // auto disabled
    step(1, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 1, 1, 0, 0);
    chk("R11 no auto", startPulse, 0);

    // enable off
    step(0, 1, 1, 0, 1, 0, 0);
    step(0, 1, 1, 1, 1, 0, 1);
    chk("R4 no start off", busy, 0);
    step(1, 1, 0, 0, 4, 0, 0);
    chk("R4 started", busy, 1);
    step(0, 0, 0, 0, 4, 1, 1);
    chk("R4 abort", busy, 0); chk("R4 no flag", irqFlag, 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 16) != 0, ($urandom % 10) == 0, ($urandom % 2) == 1,
           ($urandom % 3) == 0 ? ~trigIn : trigIn, CH_W'($urandom),
           ($urandom % 5) == 0, ($urandom % 10) == 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule